// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register Unit

This block holds the configuration state of an SDRAM memory controller and presents it on a device control register bus through two bus addresses. One address is a pointer register. The other is a data window, and every access to the window reaches the internal register named by the current pointer value. The internal registers hold two error-status words, an error address, the controller configuration and its status, the refresh and power-management settings, one configuration word per bank, a timing word, and the ECC configuration and ECC error status.

The block turns each bank configuration word into an enable, a base address and a byte size. A master switch in the configuration register gates all of these. A combinational address probe reports whether a physical address falls inside a mapped bank, and which bank it is. An interrupt output is high while the ECC error-status register is nonzero. Error events from the rest of the controller set bits in the error-status words, and software clears those bits by writing ones.

Top module: `sdram_cfg_unit`

## Requirements
- R1: A write to bus address 0x010 loads the 32-bit pointer, and a read of 0x010 returns it. A read of 0x011 returns, in the same cycle, the register selected by the pointer. A read of any other bus address returns 0.
- R2: After reset the reads are: pointer 0, both error words 0, error address 0, configuration 0x00800000, status 0, refresh 0x05F00000, power management 0x07C00000, every bank word 0, ECC configuration 0, ECC error status 0. The interrupt is low.
- R3: The error words sit at pointer 0x00 and 0x08. Writing ones through the window clears those bits. An error event input sets its bit every cycle it is high, and a set in the same cycle as a clear wins.
- R4: The configuration word (pointer 0x20) is stored ANDed with 0xFFE00000. A 0-to-1 change of bit 31 clears status bit 31, and a 1-to-0 change sets it. A 0-to-1 change of bit 30 sets status bit 30, and a 1-to-0 change clears it. Writes to the status word (pointer 0x24) have no effect.
- R5: The refresh word (0x30) is stored ANDed with 0x3FF80000. The power-management word (0x34) keeps bits 31:27 of the written value and ORs in 0x07C00000. The ECC configuration (0x94) is stored ANDed with 0x00F00000. The error address (0x10) stores the full value.
- R6: The timing pointer 0x80 and any pointer without a register read as 0xFFFFFFFF. Writes to them change no other register.
- R7: The bank words sit at pointer 0x40 + 4*n and are stored ANDed with 0xFFDEE001. Bit 0 is the enable, bits 31:23 give the base address bits 31:23, and bits 19:17 give a shift s with size = 4 MiB << s. The value s = 7 is invalid.
- R8: A bank's enable output is high only when configuration bit 31, the bank's bit 0 and a valid s are all present. Its base output is the stored base, and its size output is the decoded size, or 0 when s = 7.
- R9: The ECC error status (0x98) is stored ANDed with 0xFFF0F000. The interrupt is high exactly while that stored value is nonzero, one clock after the write.
- R10: The probe hits when some enabled bank satisfies base <= addr < base + size. It reports the lowest-numbered bank that hits, and reports bank 0 with no hit otherwise.
- R11: With the write strobe low, no register changes, except through the error event inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Bus register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| err0_set | input | 32 | Error event bits for error word 0 |
| err1_set | input | 32 | Error event bits for error word 1 |
| probe_addr | input | 32 | Physical address to classify |
| probe_hit | output | 1 | Address falls in a mapped bank |
| probe_bank | output | 2 | Lowest-numbered bank that hits |
| bank_en | output | 4 | Per-bank mapped flag |
| bank_base | output | 128 | Per-bank base address, 32 bits per bank |
| bank_size | output | 128 | Per-bank size in bytes, 32 bits per bank |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The hardest state to reach from the ports is a probe address that lies inside two enabled banks whose ranges overlap, while the same address also sits on the exact last byte or the first byte past a range. To get there, the stimulus programs banks with chosen base and shift values, turns the master switch off and on again, and aims the probe at base - 1, base, base + size - 1 and base + size. Constrained-random writes through the window then reprogram banks, and they include invalid shifts and cleared enables. A bench model checks the pointer path, the masking and the status edge rules on every read.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int RW = 32;

  localparam logic [RW-1:0] OFF_ERR0  = 32'h00;
  localparam logic [RW-1:0] OFF_ERR1  = 32'h08;
  localparam logic [RW-1:0] OFF_EADDR = 32'h10;
  localparam logic [RW-1:0] OFF_CFG   = 32'h20;
  localparam logic [RW-1:0] OFF_STAT  = 32'h24;
  localparam logic [RW-1:0] OFF_RFSH  = 32'h30;
  localparam logic [RW-1:0] OFF_PWR   = 32'h34;
  localparam logic [RW-1:0] OFF_BANK0 = 32'h40;
  localparam logic [RW-1:0] OFF_TIM   = 32'h80;
  localparam logic [RW-1:0] OFF_ECFG  = 32'h94;
  localparam logic [RW-1:0] OFF_ESTS  = 32'h98;

  localparam logic [RW-1:0] CFG_KEEP  = 32'hFFE0_0000;
  localparam logic [RW-1:0] RFSH_KEEP = 32'h3FF8_0000;
  localparam logic [RW-1:0] PWR_KEEP  = 32'hF800_0000;
  localparam logic [RW-1:0] PWR_FORCE = 32'h07C0_0000;
  localparam logic [RW-1:0] ECFG_KEEP = 32'h00F0_0000;
  localparam logic [RW-1:0] ESTS_KEEP = 32'hFFF0_F000;
  localparam logic [RW-1:0] BANK_KEEP = 32'hFFDE_E001;

  localparam logic [RW-1:0] CFG_RST   = 32'h0080_0000;
  localparam logic [RW-1:0] RFSH_RST  = 32'h05F0_0000;
  localparam logic [RW-1:0] PWR_RST   = 32'h07C0_0000;
  localparam logic [RW-1:0] ALL_ONES  = 32'hFFFF_FFFF;

  localparam int CFG_ON_BIT  = 31;
  localparam int CFG_AUX_BIT = 30;
  localparam logic [RW-1:0] UNIT_BYTES = 32'h0040_0000;

  function automatic logic [RW-1:0] span_of(input logic [2:0] shf);
    if (shf == 3'd7) return '0;
    return UNIT_BYTES << shf;
  endfunction
endpackage

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int NB  = 4,
  parameter int ABW = 10,
  parameter logic [ABW-1:0] IDX_ADDR  = 10'h010,
  parameter logic [ABW-1:0] DATA_ADDR = 10'h011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ABW-1:0]    bus_addr,
  input  logic              bus_wr,
  input  logic [RW-1:0]     bus_wdata,
  input  logic [RW-1:0]     err0_set,
  input  logic [RW-1:0]     err1_set,
  output logic [RW-1:0]     bus_rdata,
  output logic [NB-1:0][RW-1:0] bank_q,
  output logic [RW-1:0]     idx_q,
  output logic [RW-1:0]     cfg_q,
  output logic [RW-1:0]     stat_q,
  output logic [RW-1:0]     err0_q,
  output logic [RW-1:0]     ests_q
);
  logic [RW-1:0] err1_q, eaddr_q, rfsh_q, pwr_q, ecfg_q;
  logic [RW-1:0] idx_d, err0_d, err1_d, eaddr_d, cfg_d, stat_d;
  logic [RW-1:0] rfsh_d, pwr_d, ecfg_d, ests_d, new_cfg;
  logic [NB-1:0][RW-1:0] bank_d;
  logic wr_idx, wr_win, upd_en;

  assign wr_idx = bus_wr && (bus_addr == IDX_ADDR);
  assign wr_win = bus_wr && (bus_addr == DATA_ADDR);
  assign upd_en = bus_wr || (|err0_set) || (|err1_set);
  assign new_cfg = bus_wdata & CFG_KEEP;

  always_comb begin
    idx_d   = idx_q;
    err0_d  = err0_q | err0_set;
    err1_d  = err1_q | err1_set;
    eaddr_d = eaddr_q;
    cfg_d   = cfg_q;
    stat_d  = stat_q;
    rfsh_d  = rfsh_q;
    pwr_d   = pwr_q;
    ecfg_d  = ecfg_q;
    ests_d  = ests_q;
    bank_d  = bank_q;
    if (wr_idx) idx_d = bus_wdata;
    if (wr_win) begin
      case (idx_q)
        OFF_ERR0:  err0_d  = (err0_q & ~bus_wdata) | err0_set;
        OFF_ERR1:  err1_d  = (err1_q & ~bus_wdata) | err1_set;
        OFF_EADDR: eaddr_d = bus_wdata;
        OFF_CFG: begin
          if (!cfg_q[CFG_ON_BIT] && new_cfg[CFG_ON_BIT])      stat_d[CFG_ON_BIT] = 1'b0;
          else if (cfg_q[CFG_ON_BIT] && !new_cfg[CFG_ON_BIT]) stat_d[CFG_ON_BIT] = 1'b1;
          if (!cfg_q[CFG_AUX_BIT] && new_cfg[CFG_AUX_BIT])      stat_d[CFG_AUX_BIT] = 1'b1;
          else if (cfg_q[CFG_AUX_BIT] && !new_cfg[CFG_AUX_BIT]) stat_d[CFG_AUX_BIT] = 1'b0;
          cfg_d = new_cfg;
        end
        OFF_RFSH:  rfsh_d = bus_wdata & RFSH_KEEP;
        OFF_PWR:   pwr_d  = (bus_wdata & PWR_KEEP) | PWR_FORCE;
        OFF_ECFG:  ecfg_d = bus_wdata & ECFG_KEEP;
        OFF_ESTS:  ests_d = bus_wdata & ESTS_KEEP;
        default: ;
      endcase
      for (int i = 0; i < NB; i++) begin
        if (idx_q == OFF_BANK0 + RW'(4 * i)) bank_d[i] = bus_wdata & BANK_KEEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      err0_q  <= '0;
      err1_q  <= '0;
      eaddr_q <= '0;
      cfg_q   <= CFG_RST;
      stat_q  <= '0;
      rfsh_q  <= RFSH_RST;
      pwr_q   <= PWR_RST;
      ecfg_q  <= '0;
      ests_q  <= '0;
      bank_q  <= '0;
    end else if (upd_en) begin
      idx_q   <= idx_d;
      err0_q  <= err0_d;
      err1_q  <= err1_d;
      eaddr_q <= eaddr_d;
      cfg_q   <= cfg_d;
      stat_q  <= stat_d;
      rfsh_q  <= rfsh_d;
      pwr_q   <= pwr_d;
      ecfg_q  <= ecfg_d;
      ests_q  <= ests_d;
      bank_q  <= bank_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == IDX_ADDR) begin
      bus_rdata = idx_q;
    end else if (bus_addr == DATA_ADDR) begin
      case (idx_q)
        OFF_ERR0:  bus_rdata = err0_q;
        OFF_ERR1:  bus_rdata = err1_q;
        OFF_EADDR: bus_rdata = eaddr_q;
        OFF_CFG:   bus_rdata = cfg_q;
        OFF_STAT:  bus_rdata = stat_q;
        OFF_RFSH:  bus_rdata = rfsh_q;
        OFF_PWR:   bus_rdata = pwr_q;
        OFF_ECFG:  bus_rdata = ecfg_q;
        OFF_ESTS:  bus_rdata = ests_q;
        OFF_TIM:   bus_rdata = ALL_ONES;
        default:   bus_rdata = ALL_ONES;
      endcase
      for (int i = 0; i < NB; i++) begin
        if (idx_q == OFF_BANK0 + RW'(4 * i)) bus_rdata = bank_q[i];
      end
    end
  end
endmodule

// File: rtl/sdram_bank_decode.sv
module sdram_bank_decode
  import sdram_cfg_pkg::*;
(
  input  logic          ctrl_on,
  input  logic          en_bit,
  input  logic [8:0]    base_hi,
  input  logic [2:0]    shf,
  output logic          bank_on,
  output logic [RW-1:0] base,
  output logic [RW-1:0] bytes
);
  assign base    = {base_hi, 23'd0};
  assign bytes   = span_of(shf);
  assign bank_on = ctrl_on && en_bit && (shf != 3'd7);
endmodule

// File: rtl/sdram_addr_match.sv
module sdram_addr_match
  import sdram_cfg_pkg::*;
#(
  parameter int NB = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [NB-1:0]         bank_on,
  input  logic [NB-1:0][RW-1:0] base,
  input  logic [NB-1:0][RW-1:0] bytes,
  input  logic [RW-1:0]         addr,
  output logic                  hit,
  output logic [BW-1:0]         bank
);
  logic [NB-1:0] in_rng;

  for (genvar g = 0; g < NB; g++) begin : g_rng
    logic [RW:0] top_x;
    assign top_x = {1'b0, base[g]} + {1'b0, bytes[g]};
    assign in_rng[g] = bank_on[g] && (addr >= base[g]) && ({1'b0, addr} < top_x);
  end

  always_comb begin
    hit  = 1'b0;
    bank = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (in_rng[i]) begin
        hit  = 1'b1;
        bank = BW'(i);
      end
    end
  end
endmodule

// File: rtl/sdram_cfg_unit.sv
module sdram_cfg_unit
  import sdram_cfg_pkg::*;
#(
  parameter int NB  = 4,
  parameter int ABW = 10,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ABW-1:0]   bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [31:0]      err0_set,
  input  logic [31:0]      err1_set,
  input  logic [31:0]      probe_addr,
  output logic             probe_hit,
  output logic [BW-1:0]    probe_bank,
  output logic [NB-1:0]    bank_en,
  output logic [NB*32-1:0] bank_base,
  output logic [NB*32-1:0] bank_size,
  output logic             ecc_irq
);
  logic [NB-1:0][RW-1:0] bank_w, base_w, size_w;
  logic [RW-1:0] idx_w, cfg_w, stat_w, err0_w, ests_w;

  sdram_cfg_regs #(.NB(NB), .ABW(ABW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .err0_set(err0_set), .err1_set(err1_set),
    .bus_rdata(bus_rdata), .bank_q(bank_w), .idx_q(idx_w), .cfg_q(cfg_w),
    .stat_q(stat_w), .err0_q(err0_w), .ests_q(ests_w)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_decode u_dec (
      .ctrl_on(cfg_w[CFG_ON_BIT]), .en_bit(bank_w[g][0]),
      .base_hi(bank_w[g][31:23]), .shf(bank_w[g][19:17]),
      .bank_on(bank_en[g]), .base(base_w[g]), .bytes(size_w[g])
    );
    assign bank_base[g*32 +: 32] = base_w[g];
    assign bank_size[g*32 +: 32] = size_w[g];
  end

  sdram_addr_match #(.NB(NB)) u_match (
    .bank_on(bank_en), .base(base_w), .bytes(size_w), .addr(probe_addr),
    .hit(probe_hit), .bank(probe_bank)
  );

  assign ecc_irq = |ests_w;
endmodule

// File: rtl/sdram_cfg_chk.sv
module sdram_cfg_chk
  import sdram_cfg_pkg::*;
#(
  parameter int NB  = 4,
  parameter int ABW = 10,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ABW-1:0]  bus_addr,
  input logic            bus_wr,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     err0_set,
  input logic            probe_hit,
  input logic [BW-1:0]   probe_bank,
  input logic [NB-1:0]   bank_en,
  input logic            ecc_irq,
  input logic [31:0]     idx_w,
  input logic [31:0]     cfg_w,
  input logic [31:0]     stat_w,
  input logic [31:0]     err0_w
);
  logic win_wr;
  assign win_wr = bus_wr && (bus_addr == ABW'(17));

  AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && idx_w == OFF_ERR0 && err0_set == '0) |=> ((err0_w & $past(bus_wdata)) == '0)); // R3
  AST_DISABLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_w[CFG_ON_BIT]) |-> stat_w[CFG_ON_BIT]); // R4
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && idx_w == OFF_STAT) |=> $stable(stat_w)); // R4
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && idx_w == OFF_ESTS && (bus_wdata & ESTS_KEEP) != '0) |=> ecc_irq); // R9
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && idx_w == OFF_ESTS && (bus_wdata & ESTS_KEEP) == '0) |=> !ecc_irq); // R9
  AST_HIT_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit |-> bank_en[probe_bank]); // R10
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_w[CFG_ON_BIT] |-> (!probe_hit && bank_en == '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(cfg_w) && $stable(idx_w) && $stable(stat_w))); // R11
endmodule

bind sdram_cfg_unit sdram_cfg_chk #(.NB(NB), .ABW(ABW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .err0_set(err0_set), .probe_hit(probe_hit),
  .probe_bank(probe_bank), .bank_en(bank_en), .ecc_irq(ecc_irq),
  .idx_w(idx_w), .cfg_w(cfg_w), .stat_w(stat_w), .err0_w(err0_w)
);

// File: tb/tb_sdram_cfg_unit.sv
module tb_sdram_cfg_unit;
  localparam int PERIOD = 10;
  localparam logic [9:0] A_IDX = 10'h010;
  localparam logic [9:0] A_WIN = 10'h011;

  logic clk, rst_n, bus_wr, probe_hit, ecc_irq;
  logic [9:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, err0_set, err1_set, probe_addr;
  logic [1:0] probe_bank;
  logic [3:0] bank_en;
  logic [127:0] bank_base, bank_size;

  int total = 0, bad = 0;
  bit ended = 0;

  logic [31:0] m_idx, m_e0, m_e1, m_ea, m_cfg, m_st, m_rf, m_pw, m_ec, m_es;
  logic [31:0] m_bk [4];

  sdram_cfg_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err0_set(err0_set),
    .err1_set(err1_set), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .probe_bank(probe_bank), .bank_en(bank_en), .bank_base(bank_base),
    .bank_size(bank_size), .ecc_irq(ecc_irq)
  );

  initial clk = 0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  function automatic logic [31:0] span(input logic [2:0] s);
    return (s == 3'd7) ? 32'd0 : (32'h0040_0000 << s);
  endfunction

  function automatic logic on_bank(input int i);
    return m_cfg[31] && m_bk[i][0] && (m_bk[i][19:17] != 3'd7);
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] ix);
    case (ix)
      32'h00: return m_e0;
      32'h08: return m_e1;
      32'h10: return m_ea;
      32'h20: return m_cfg;
      32'h24: return m_st;
      32'h30: return m_rf;
      32'h34: return m_pw;
      32'h40: return m_bk[0];
      32'h44: return m_bk[1];
      32'h48: return m_bk[2];
      32'h4C: return m_bk[3];
      32'h94: return m_ec;
      32'h98: return m_es;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] pick_off(input int k);
    case (k)
      0: return 32'h00;  1: return 32'h08;  2: return 32'h10;  3: return 32'h20;
      4: return 32'h24;  5: return 32'h30;  6: return 32'h34;  7: return 32'h40;
      8: return 32'h44;  9: return 32'h48;  10: return 32'h4C; 11: return 32'h80;
      12: return 32'h94; 13: return 32'h98; default: return 32'h5C;
    endcase
  endfunction

  task automatic model_win_write(input logic [31:0] v, input logic [31:0] s0, input logic [31:0] s1);
    logic [31:0] nc;
    m_e0 = m_e0 | s0;
    m_e1 = m_e1 | s1;
    case (m_idx)
      32'h00: m_e0 = (m_e0 & ~v) | s0;
      32'h08: m_e1 = (m_e1 & ~v) | s1;
      32'h10: m_ea = v;
      32'h20: begin
        nc = v & 32'hFFE0_0000;
        if (!m_cfg[31] && nc[31]) m_st[31] = 0; else if (m_cfg[31] && !nc[31]) m_st[31] = 1;
        if (!m_cfg[30] && nc[30]) m_st[30] = 1; else if (m_cfg[30] && !nc[30]) m_st[30] = 0;
        m_cfg = nc;
      end
      32'h30: m_rf = v & 32'h3FF8_0000;
      32'h34: m_pw = (v & 32'hF800_0000) | 32'h07C0_0000;
      32'h40: m_bk[0] = v & 32'hFFDE_E001;
      32'h44: m_bk[1] = v & 32'hFFDE_E001;
      32'h48: m_bk[2] = v & 32'hFFDE_E001;
      32'h4C: m_bk[3] = v & 32'hFFDE_E001;
      32'h94: m_ec = v & 32'h00F0_0000;
      32'h98: m_es = v & 32'hFFF0_F000;
      default: ;
    endcase
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1;
    if (a == A_IDX) m_idx = v;
    else if (a == A_WIN) model_win_write(v, 32'd0, 32'd0);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic set_reg(input logic [31:0] off, input logic [31:0] v);
    bus_write(A_IDX, off);
    bus_write(A_WIN, v);
  endtask

  task automatic read_check(input string req, input logic [31:0] off);
    bus_write(A_IDX, off);
    bus_addr = A_WIN;
    #1;
    check(req, bus_rdata, exp_read(off));
  endtask

  task automatic probe_check(input string req, input logic [31:0] a);
    logic eh;
    logic [1:0] eb;
    eh = 0; eb = 0;
    for (int i = 3; i >= 0; i--) begin
      if (on_bank(i) && a >= {m_bk[i][31:23], 23'd0} &&
          ({1'b0, a} < {1'b0, m_bk[i][31:23], 23'd0} + {1'b0, span(m_bk[i][19:17])})) begin
        eh = 1; eb = 2'(i);
      end
    end
    probe_addr = a;
    #1;
    check({req, " hit"}, {31'd0, probe_hit}, {31'd0, eh});
    check({req, " bank"}, {30'd0, probe_bank}, {30'd0, eb});
  endtask

  task automatic bank_out_check(input string req);
    for (int i = 0; i < 4; i++) begin
      check({req, " en"}, {31'd0, bank_en[i]}, {31'd0, on_bank(i)});
      check({req, " base"}, bank_base[i*32 +: 32], {m_bk[i][31:23], 23'd0});
      check({req, " size"}, bank_size[i*32 +: 32], span(m_bk[i][19:17]));
    end
  endtask

  initial begin
    void'($urandom(1234));
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    err0_set = 0; err1_set = 0; probe_addr = 0;
    m_idx = 0; m_e0 = 0; m_e1 = 0; m_ea = 0; m_cfg = 32'h0080_0000; m_st = 0;
    m_rf = 32'h05F0_0000; m_pw = 32'h07C0_0000; m_ec = 0; m_es = 0;
    for (int i = 0; i < 4; i++) m_bk[i] = 0;
    #(PERIOD * 3);
    @(negedge clk); rst_n = 1;

    // R2 reset values
    bus_addr = A_IDX; #1;
    check("R2 idx", bus_rdata, 32'd0);
    check("R2 irq", {31'd0, ecc_irq}, 32'd0);
    for (int k = 0; k < 15; k++) read_check("R2 reset read", pick_off(k));
    bank_out_check("R2 bank outs");

    // R1 pointer readback and foreign address
    bus_write(A_IDX, 32'hDEAD_BEEF);
    bus_addr = A_IDX; #1; check("R1 idx rb", bus_rdata, 32'hDEAD_BEEF);
    bus_addr = 10'h012; #1; check("R1 other addr", bus_rdata, 32'd0);
    bus_addr = A_WIN; #1; check("R6 unknown idx", bus_rdata, 32'hFFFF_FFFF);

    // R5 masks, R6 timing
    set_reg(32'h30, 32'hFFFF_FFFF); read_check("R5 refresh", 32'h30);
    set_reg(32'h34, 32'h0000_0000); read_check("R5 pm", 32'h34);
    set_reg(32'h94, 32'hFFFF_FFFF); read_check("R5 ecc cfg", 32'h94);
    set_reg(32'h10, 32'h1234_5678); read_check("R5 eaddr", 32'h10);
    set_reg(32'h80, 32'h0000_0000); read_check("R6 timing", 32'h80);
    read_check("R6 others intact", 32'h30);

    // R4 status edges and read-only
    set_reg(32'h20, 32'hC000_0000); read_check("R4 cfg", 32'h20); read_check("R4 status up", 32'h24);
    set_reg(32'h24, 32'hFFFF_FFFF); read_check("R4 status ro", 32'h24);
    set_reg(32'h20, 32'h0000_0000); read_check("R4 status down", 32'h24);
    check("R4 status model", m_st, 32'h8000_0000);

    // R3 error set / clear
    @(negedge clk); err0_set = 32'h0000_00F0; err1_set = 32'h8000_0001;
    m_e0 |= 32'hF0; m_e1 |= 32'h8000_0001;
    @(negedge clk); err0_set = 0; err1_set = 0;
    read_check("R3 set0", 32'h00); read_check("R3 set1", 32'h08);
    set_reg(32'h00, 32'h0000_0030); read_check("R3 w1c", 32'h00);
    bus_write(A_IDX, 32'h00);
    @(negedge clk);
    bus_addr = A_WIN; bus_wdata = 32'hFF; bus_wr = 1; err0_set = 32'h01;
    model_win_write(32'hFF, 32'h01, 32'h0);
    @(negedge clk); bus_wr = 0; err0_set = 0;
    #1; check("R3 set wins", bus_rdata, 32'h01);

    // R9 interrupt
    set_reg(32'h98, 32'h000F_0FFF); #1; check("R9 masked zero irq", {31'd0, ecc_irq}, 32'd0);
    set_reg(32'h98, 32'h0010_0000); #1; check("R9 irq up", {31'd0, ecc_irq}, 32'd1);
    read_check("R9 ests", 32'h98);
    set_reg(32'h98, 32'h0); #1; check("R9 irq down", {31'd0, ecc_irq}, 32'd0);

    // R7/R8/R10 directed banks, overlap and edges
    set_reg(32'h40, 32'h1000_0000 | (32'd2 << 17) | 32'h1);
    set_reg(32'h44, 32'h1080_0000 | (32'd1 << 17) | 32'h1);
    set_reg(32'h48, 32'h2000_0000 | (32'd7 << 17) | 32'h1);
    set_reg(32'h4C, 32'h3000_0000 | (32'd6 << 17));
    read_check("R7 bank mask", 32'h40);
    bank_out_check("R8 ctrl off");
    probe_check("R10 off", 32'h1000_0000);
    set_reg(32'h20, 32'h8000_0000);
    read_check("R4 enable clears", 32'h24);
    bank_out_check("R8 ctrl on");
    probe_check("R10 below", 32'h0FFF_FFFF);
    probe_check("R10 base", 32'h1000_0000);
    probe_check("R10 overlap", 32'h1090_0000);
    probe_check("R10 last", 32'h10FF_FFFF);
    probe_check("R10 past", 32'h1100_0000);
    probe_check("R10 invalid size", 32'h2000_0000);
    probe_check("R10 disabled bank", 32'h3000_0000);
    set_reg(32'h4C, 32'hF000_0000 | (32'd6 << 17) | 32'h1);
    probe_check("R10 top", 32'hFFFF_FFFF);

    // R11 idle strobe
    @(negedge clk); bus_addr = A_WIN; bus_wdata = 32'h0; bus_wr = 0;
    @(negedge clk); @(negedge clk);
    read_check("R11 idle", 32'h20);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [31:0] v;
      k = int'($urandom_range(0, 14));
      v = $urandom;
      if (k >= 7 && k <= 10 && ($urandom_range(0, 3) != 0)) v[19:17] = 3'($urandom_range(0, 6));
      if (k == 3 && ($urandom_range(0, 2) != 0)) v[31] = 1'b1;
      set_reg(pick_off(k), v);
      read_check("R1 random read", pick_off(int'($urandom_range(0, 14))));
      if (n % 4 == 0) begin
        int b;
        b = int'($urandom_range(0, 3));
        probe_check("R10 random", {m_bk[b][31:23], 23'd0} + $urandom_range(0, 32'h0080_0000) - 32'h0010_0000);
        bank_out_check("R8 random");
        check("R9 random irq", {31'd0, ecc_irq}, {31'd0, m_es != 0});
      end
    end
    finish_run();
  end
endmodule